// File: doc/BRIEF.md
# Clock-Synchronous Framed Serial Receiver

This block takes command bytes from one serial data line. The line is sampled on every rising edge of the shared system clock, and that clock may be free-running or gated. The block does not oversample, so each clock edge carries exactly one bit. A character is a low start bit followed by a fixed number of data bits. Stop bits are optional, so a new character may begin on the edge right after the last data bit of the previous one.

Every received word appears on a parallel output together with a one-cycle valid strobe. The block also watches the line for a long run of zeros. When the run reaches a set length, it raises a one-cycle break strobe that the surrounding logic uses as an interface reset. No word is delivered for the zero run itself. After a reset the receiver ignores the line until it has seen a run of ones long enough to know it is between characters. After a break it waits for a single 1 before it looks for a new start bit.

Top module: `sync_frame_rx`

## Requirements
- R1: After reset no frame is accepted until SYNC_LEN (default 10) consecutive 1 samples have been taken. A 0 sample restarts that count, so 9 ones followed by a 0 leave the receiver unsynchronised.
- R2: Once the receiver is synchronised and idle, a 0 sample is taken as the start bit. The next DATA_BITS (default 8) rising edges sample the data bits. With LSB_FIRST=1 the first data bit lands in bit 0 of rx_byte.
- R3: rx_valid stays 0 while a frame is arriving. It goes high for exactly one cycle, starting after the rising edge that samples the bit following the last data bit. rx_byte keeps the delivered word until the next delivery.
- R4: No stop bit is needed. A 0 sampled directly after the last data bit is the start bit of the next frame.
- R5: The line's zeros are counted across frame boundaries. rx_break goes high for one cycle after the edge that samples the BREAK_LEN-th (default 10th) consecutive 0. Further zeros in the same run raise no second pulse.
- R6: A frame is dropped without rx_valid if its trailing zeros belong to a run that reaches BREAK_LEN on the following edge. An all-zero word followed by a 1 is delivered as 0x00.
- R7: After a break, 0 samples are ignored until a 1 is sampled. The first 0 after that 1 is a start bit.
- R8: A high rst at a rising edge clears the bit counter, the shift register and the zero-run counter. It drives rx_valid and rx_break low after that edge and returns the receiver to the unsynchronised state of R1.
- R9: With LSB_FIRST=0 the first data bit lands in the most significant bit of rx_byte.
- R10: rx_valid and rx_break are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock. The line is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdi | input | 1 | Serial data line, idle high |
| rx_valid | output | 1 | One-cycle strobe: rx_byte holds a new word |
| rx_byte | output | DATA_BITS | Last word received |
| rx_break | output | 1 | One-cycle strobe: a break run was detected |

## Verification
The bench builds instance u0 with the default values: 8 data bits, a break length of 10, a 10-sample synchronisation run, LSB-first order and break detection on. A second instance, u1, takes the same line with LSB_FIRST=0, so every frame also checks the reversed bit order. The break length is exactly two more than the data width. This brings within reach the one case where an all-zero word and a break can only be told apart by the next sample, and the bench drives both outcomes. Because zeros are counted across frames, the bench also sends back-to-back frames without stop bits whose zero runs come close to the limit but stay below it.

// File: rtl/srx_pkg.sv
package srx_pkg;
   typedef enum logic [1:0] {
      ST_SYNC = 2'd0,
      ST_IDLE = 2'd1,
      ST_DATA = 2'd2,
      ST_HOLD = 2'd3
   } srx_state_e;
endpackage

// File: rtl/srx_linesync.sv
// Counts consecutive high samples while the receiver is unsynchronised.
module srx_linesync #(
   parameter int SYNC_LEN = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic sdi,
   input  logic armed,
   output logic sync_ok
);
   localparam int SCW = $clog2(SYNC_LEN + 1);
   localparam logic [SCW-1:0] LAST = SCW'(SYNC_LEN - 1);

   logic [SCW-1:0] high_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         high_cnt <= '0;
      end else if (!armed || !sdi) begin
         high_cnt <= '0;
      end else if (high_cnt != LAST) begin
         high_cnt <= high_cnt + 1'b1;
      end
   end

   assign sync_ok = armed && sdi && (high_cnt == LAST);

   // R1: synchronisation completes only on a high sample that follows another high sample
   p_sync_after_high_r1: assert property (@(posedge clk) disable iff (rst)
      (sync_ok && SYNC_LEN > 1) |-> $past(sdi));
   p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
      high_cnt <= LAST);
endmodule

// File: rtl/srx_zerorun.sv
// Counts consecutive zeros on the line and flags a break.
module srx_zerorun #(
   parameter int BREAK_LEN = 10,
   parameter bit BREAK_EN  = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic sdi,
   output logic brk_now,
   output logic brk
);
   localparam int RCW = $clog2(BREAK_LEN + 1);

   generate
      if (BREAK_EN) begin : g_detect
         localparam logic [RCW-1:0] FULL = RCW'(BREAK_LEN);
         localparam logic [RCW-1:0] EDGE = RCW'(BREAK_LEN - 1);
         logic [RCW-1:0] run;

         always_ff @(posedge clk) begin
            if (rst) begin
               run <= '0;
               brk <= 1'b0;
            end else begin
               brk <= brk_now;
               if (sdi) begin
                  run <= '0;
               end else if (run != FULL) begin
                  run <= run + 1'b1;
               end
            end
         end

         assign brk_now = !sdi && (run == EDGE);

         // R5: a break pulse lasts one cycle and follows a zero sample
         p_brk_single_r5: assert property (@(posedge clk) disable iff (rst)
            brk |=> !brk);
         p_brk_on_zero_r5: assert property (@(posedge clk) disable iff (rst)
            brk |-> !$past(sdi));
      end else begin : g_nodetect
         assign brk_now = 1'b0;
         assign brk     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/srx_deframe.sv
// Frame state machine, shift register and deferred word delivery.
module srx_deframe
   import srx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sdi,
   input  logic                 sync_ok,
   input  logic                 brk_now,
   output logic                 armed,
   output logic                 byte_vld,
   output logic [DATA_BITS-1:0] byte_data
);
   localparam int BCW = $clog2(DATA_BITS);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_BITS - 1);

   srx_state_e           state;
   logic [DATA_BITS-1:0] shreg;
   logic [DATA_BITS-1:0] shift_nxt;
   logic [BCW-1:0]       bit_cnt;
   logic                 pend_vld;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign shift_nxt = {sdi, shreg[DATA_BITS-1:1]};
      end else begin : g_msb
         assign shift_nxt = {shreg[DATA_BITS-2:0], sdi};
      end
   endgenerate

   assign armed = (state == ST_SYNC);

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_SYNC;
         shreg     <= '0;
         bit_cnt   <= '0;
         pend_vld  <= 1'b0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
      end else begin
         // shreg is untouched in the cycle after a frame, even if a new start bit arrives
         byte_vld <= pend_vld && !brk_now;
         if (pend_vld && !brk_now) begin
            byte_data <= shreg;
         end
         pend_vld <= 1'b0;
         if (brk_now) begin
            state   <= ST_HOLD;
            bit_cnt <= '0;
         end else begin
            case (state)
               ST_SYNC: if (sync_ok) state <= ST_IDLE;
               ST_IDLE: begin
                  if (!sdi) begin
                     state   <= ST_DATA;
                     bit_cnt <= '0;
                  end
               end
               ST_DATA: begin
                  shreg <= shift_nxt;
                  if (bit_cnt == LAST_BIT) begin
                     pend_vld <= 1'b1;
                     bit_cnt  <= '0;
                     state    <= ST_IDLE;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                  end
               end
               ST_HOLD: if (sdi) state <= ST_IDLE;
               default: state <= ST_SYNC;
            endcase
         end
      end
   end

   // R3: a delivery strobe is never longer than one cycle
   p_vld_single_r3: assert property (@(posedge clk) disable iff (rst)
      byte_vld |=> !byte_vld);
   // R3: delivery follows the cycle in which the frame had just closed
   p_vld_after_frame_r3: assert property (@(posedge clk) disable iff (rst)
      byte_vld |-> ($past(state) == ST_IDLE));
   // R7: low samples keep the receiver waiting after a break
   p_hold_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_HOLD && !sdi) |=> (state == ST_HOLD));
   // R1: no frame starts before synchronisation
   p_sync_blocks_r1: assert property (@(posedge clk) disable iff (rst)
      (state == ST_SYNC && !sync_ok) |=> (state == ST_SYNC || state == ST_HOLD));
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx #(
   parameter int DATA_BITS = 8,
   parameter int BREAK_LEN = 10,
   parameter int SYNC_LEN  = 10,
   parameter bit LSB_FIRST = 1'b1,
   parameter bit BREAK_EN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sdi,
   output logic                 rx_valid,
   output logic [DATA_BITS-1:0] rx_byte,
   output logic                 rx_break
);
   generate
      if (DATA_BITS < 2) begin : g_bad_bits
         $error("sync_frame_rx: DATA_BITS must be at least 2");
      end
      if (SYNC_LEN < 1) begin : g_bad_sync
         $error("sync_frame_rx: SYNC_LEN must be at least 1");
      end
      if (BREAK_EN && (BREAK_LEN < DATA_BITS + 2)) begin : g_bad_brk
         $error("sync_frame_rx: BREAK_LEN must exceed a start bit plus a zero word");
      end
   endgenerate

   logic armed;
   logic sync_ok;
   logic brk_now;

   srx_linesync #(.SYNC_LEN(SYNC_LEN)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .sdi     (sdi),
      .armed   (armed),
      .sync_ok (sync_ok)
   );

   srx_zerorun #(.BREAK_LEN(BREAK_LEN), .BREAK_EN(BREAK_EN)) u_zrun (
      .clk     (clk),
      .rst     (rst),
      .sdi     (sdi),
      .brk_now (brk_now),
      .brk     (rx_break)
   );

   srx_deframe #(.DATA_BITS(DATA_BITS), .LSB_FIRST(LSB_FIRST)) u_frame (
      .clk       (clk),
      .rst       (rst),
      .sdi       (sdi),
      .sync_ok   (sync_ok),
      .brk_now   (brk_now),
      .armed     (armed),
      .byte_vld  (rx_valid),
      .byte_data (rx_byte)
   );

   // R10: word and break strobes are exclusive
   p_excl_r10: assert property (@(posedge clk) disable iff (rst)
      !(rx_valid && rx_break));
   // R8: reset silences both strobes
   p_rst_clear_r8: assert property (@(posedge clk)
      rst |=> (!rx_valid && !rx_break));
endmodule

// File: tb/sim_sync_frame_rx.sv
`timescale 1ns/1ps
module sim_sync_frame_rx;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sdi = 1'b1;
   logic       vld0, brk0, vld1, brk1;
   logic [7:0] byte0, byte1;
   int         n_chk = 0;
   int         n_err = 0;
   logic       seen_vld = 1'b0;

   always #2.5 clk = ~clk;

   sync_frame_rx u0 (
      .clk(clk), .rst(rst), .sdi(sdi),
      .rx_valid(vld0), .rx_byte(byte0), .rx_break(brk0)
   );

   sync_frame_rx #(.LSB_FIRST(1'b0)) u1 (
      .clk(clk), .rst(rst), .sdi(sdi),
      .rx_valid(vld1), .rx_byte(byte1), .rx_break(brk1)
   );

   // {gap, data}: gap=1 sends one stop bit, gap=0 starts the next frame at once
   localparam logic [8:0] VEC [8] = '{
      9'h0A5, 9'h13C, 9'h0FF, 9'h080, 9'h001, 9'h05B, 9'h17E, 9'h100
   };

   function automatic logic [7:0] rev8(input logic [7:0] d);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = d[7-k];
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic b);
      sdi = b;
      @(posedge clk);
      @(negedge clk);
      if (vld0) seen_vld = 1'b1;
   endtask

   task automatic ones(input int n);
      for (int k = 0; k < n; k++) tick(1'b1);
   endtask

   task automatic frame(input logic [7:0] d);
      tick(1'b0);
      for (int k = 0; k < 8; k++) tick(d[k]);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic start_sent;
      @(negedge clk);
      rst = 1'b1;
      ones(3);
      rst = 1'b0;
      // R8: reset state
      chk("R8 reset valid", 32'(vld0), 0);
      chk("R8 reset break", 32'(brk0), 0);

      // R1: nine ones are not enough
      ones(9);
      seen_vld = 1'b0;
      frame(8'h3C);
      tick(1'b1);
      tick(1'b0);
      chk("R1 unsynced frame ignored", 32'(seen_vld), 0);
      ones(10);
      frame(8'h69);
      chk("R3 no strobe before closing bit", 32'(vld0), 0);
      tick(1'b1);
      chk("R1 synced frame valid", 32'(vld0), 1);
      chk("R1 synced frame data", 32'(byte0), 32'h69);
      tick(1'b1);
      chk("R3 strobe lasts one cycle", 32'(vld0), 0);
      chk("R3 word held", 32'(byte0), 32'h69);

      // table walk: R2 R4 R6 R9
      start_sent = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic [7:0] d;
         logic       gap;
         string      tag;
         d   = VEC[i][7:0];
         gap = VEC[i][8];
         tag = (d == 8'h00) ? "R6" : (gap ? "R2" : "R4");
         if (!start_sent) tick(1'b0);
         for (int k = 0; k < 8; k++) tick(d[k]);
         chk("R3 quiet during frame", 32'(vld0), 0);
         tick(gap);
         start_sent = !gap;
         chk({tag, " valid"}, 32'(vld0), 1);
         chk({tag, " data"}, 32'(byte0), 32'(d));
         chk("R9 msb-first data", 32'(byte1), 32'(rev8(d)));
      end
      ones(2);

      // R5 R6 R10: break run
      seen_vld = 1'b0;
      for (int k = 0; k < 9; k++) tick(1'b0);
      chk("R5 no break at nine zeros", 32'(brk0), 0);
      tick(1'b0);
      chk("R5 break at tenth zero", 32'(brk0), 1);
      chk("R6 R10 no word for zero run", 32'(vld0), 0);
      chk("R6 no word during run", 32'(seen_vld), 0);
      tick(1'b0);
      chk("R5 single pulse", 32'(brk0), 0);
      tick(1'b0);
      chk("R5 no repeat", 32'(brk0), 0);

      // R7: zero ignored, re-align after first one
      seen_vld = 1'b0;
      frame(8'hC3);
      chk("R7 nothing yet", 32'(seen_vld), 0);
      ones(3);
      chk("R7 nothing before closing bit", 32'(vld0), 0);
      tick(1'b1);
      chk("R7 realigned valid", 32'(vld0), 1);
      chk("R7 realigned data", 32'(byte0), 32'hF8);
      ones(2);

      // R8: reset mid-frame then resync required
      tick(1'b0);
      tick(1'b1);
      tick(1'b0);
      rst = 1'b1;
      tick(1'b1);
      rst = 1'b0;
      chk("R8 valid low after reset", 32'(vld0), 0);
      seen_vld = 1'b0;
      frame(8'h55);
      tick(1'b1);
      tick(1'b1);
      chk("R8 resync required", 32'(seen_vld), 0);
      ones(10);
      frame(8'h96);
      tick(1'b1);
      chk("R8 after resync", 32'(byte0), 32'h96);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule